// File: doc/BRIEF.md
# ADC Conversion Request Arbiter

This block decides which analog channel a successive-approximation converter samples next. It has three request sources. A parallel source keeps a pending mask that is filled by trigger events and serves its channels in a fixed order, lowest-numbered first. A queued source holds channel numbers in the order they were written and serves them in that order. A single-slot insertion source lets one channel be placed between two conversions of a running sequence.

Each source has a priority level, which is a configuration input. Whenever the converter is idle, the arbiter picks the source with the highest level among those that have work. It issues a one-cycle start pulse together with the channel number and a source code. It then waits for the converter's done pulse before it arbitrates again. A conversion taken by another source only removes that source's own request, so a parallel sequence that was overtaken resumes with its next pending channel.

Top module: `adc_req_arbiter`

## Requirements
- R1: When reset is released, `conv_start` and `busy` are low, `conv_ch` is 0, `conv_src` is 0, `q_empty` is high, and `q_full` and `q_ovf` are low.
- R2: A cycle with `par_trig` high ORs `par_mask` into the parallel pending mask. Among the pending bits, the lowest-numbered channel is served first, and its bit is cleared at its start. If a trigger sets that same bit in the same cycle, the bit stays pending.
- R3: The queue holds up to 4 channel numbers and serves them in the order they were written. `q_full` is high while it holds 4 entries, and `q_empty` is high while it holds none.
- R4: A write made while `q_full` is high is dropped, even if an entry leaves the queue in that same cycle. Such a write sets `q_ovf`, which stays high until reset.
- R5: The insertion source holds one channel. An `ins_req` made while a channel is already held is dropped, and this includes the cycle in which the held channel is started.
- R6: When a conversion starts, it goes to the source with work that has the highest priority value. On equal values, insertion beats queued, and queued beats parallel. `conv_src` codes the winner: 1 parallel, 2 queued, 3 insertion.
- R7: A start happens only in a cycle where `busy` was low. `conv_start` is a single-cycle pulse, with `conv_ch` and `conv_src` valid in that cycle and held afterwards. `busy` rises with the start and falls in the cycle after `conv_done` is seen.
- R8: A `conv_done` pulse that arrives while `busy` is low has no effect.
- R9: A queued or inserted conversion that starts between parallel conversions leaves the parallel pending bits unchanged, so the sequence continues with its next lowest pending channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_trig | input | 1 | Trigger event for the parallel source |
| par_mask | input | 16 | Channels made pending by the trigger |
| q_wr | input | 1 | Write one channel into the queue |
| q_wr_ch | input | 4 | Channel number to queue |
| ins_req | input | 1 | Request an inserted conversion |
| ins_ch | input | 4 | Channel number to insert |
| par_prio | input | 2 | Priority level of the parallel source |
| q_prio | input | 2 | Priority level of the queued source |
| ins_prio | input | 2 | Priority level of the insertion source |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_start | output | 1 | One-cycle start pulse for the converter |
| conv_ch | output | 4 | Channel to convert |
| conv_src | output | 2 | Source that won the arbitration |
| busy | output | 1 | A conversion is in progress |
| q_full | output | 1 | Queue holds 4 entries |
| q_empty | output | 1 | Queue holds no entries |
| q_ovf | output | 1 | A queue write was dropped (sticky) |

## Verification
Two pairs of events can fall on the same clock edge. The first is a queue write and a queue pop while the queue is full. The second is a parallel trigger and the start of the very channel that the trigger re-requests. The first is provoked by holding the converter busy until the queue is full, then releasing it while writing every cycle. The second comes from repeated triggers of channel 0 during a running sequence and from dense random traffic. A cycle-level reference model in the bench, built from the requirements, judges every output at every cycle, so the dropped write, the overflow flag and the re-pended bit are each seen at the ports.

// File: rtl/adc_arb_pkg.sv
package adc_arb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PAR  = 2'd1,
    SRC_QUE  = 2'd2,
    SRC_INS  = 2'd3
  } src_e;
endpackage

// File: rtl/adc_par_src.sv
module adc_par_src #(
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           trig,
  input  logic [NCH-1:0] mask,
  input  logic           take,
  output logic           any,
  output logic [CHW-1:0] low_ch
);
  logic [NCH-1:0] pend;
  logic [NCH-1:0] clr;

  // lowest-numbered pending channel wins
  always_comb begin
    low_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) low_ch = CHW'(i);
    end
  end

  assign any = |pend;

  always_comb begin
    clr = '0;
    if (take) clr[low_ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | (trig ? mask : '0);
  end
endmodule

// File: rtl/adc_req_fifo.sv
module adc_req_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty,
  output logic         ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign push  = wr && !full;
  assign pop   = rd && !empty;
  assign rdata = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (wr && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_ins_slot.sv
module adc_ins_slot #(
  parameter int CHW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req,
  input  logic [CHW-1:0] ch,
  input  logic           take,
  output logic           valid,
  output logic [CHW-1:0] held_ch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      held_ch <= '0;
    end else begin
      if (take) valid <= 1'b0;
      if (req && !valid) begin
        valid   <= 1'b1;
        held_ch <= ch;
      end
    end
  end
endmodule

// File: rtl/adc_arb_core.sv
module adc_arb_core
  import adc_arb_pkg::*;
#(
  parameter int CHW = 4,
  parameter int PRW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           p_v,
  input  logic [CHW-1:0] p_ch,
  input  logic [PRW-1:0] p_prio,
  input  logic           q_v,
  input  logic [CHW-1:0] q_ch,
  input  logic [PRW-1:0] q_prio,
  input  logic           i_v,
  input  logic [CHW-1:0] i_ch,
  input  logic [PRW-1:0] i_prio,
  input  logic           conv_done,
  output logic           take_p,
  output logic           take_q,
  output logic           take_i,
  output logic           conv_start,
  output logic [CHW-1:0] conv_ch,
  output logic [1:0]     conv_src,
  output logic           busy
);
  src_e           sel;
  logic [PRW-1:0] best;
  logic [CHW-1:0] sel_ch;
  logic           go;

  // later candidates win ties: insertion over queue over parallel
  always_comb begin
    sel    = SRC_NONE;
    best   = '0;
    sel_ch = p_ch;
    if (p_v) begin
      sel  = SRC_PAR;
      best = p_prio;
    end
    if (q_v && (sel == SRC_NONE || q_prio >= best)) begin
      sel    = SRC_QUE;
      best   = q_prio;
      sel_ch = q_ch;
    end
    if (i_v && (sel == SRC_NONE || i_prio >= best)) begin
      sel    = SRC_INS;
      sel_ch = i_ch;
    end
  end

  assign go     = !busy && (sel != SRC_NONE);
  assign take_p = go && (sel == SRC_PAR);
  assign take_q = go && (sel == SRC_QUE);
  assign take_i = go && (sel == SRC_INS);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_ch    <= '0;
      conv_src   <= SRC_NONE;
    end else begin
      conv_start <= 1'b0;
      if (go) begin
        busy       <= 1'b1;
        conv_start <= 1'b1;
        conv_ch    <= sel_ch;
        conv_src   <= sel;
      end else if (busy && conv_done) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_req_arbiter.sv
module adc_req_arbiter #(
  parameter int NCH    = 16,
  parameter int QDEPTH = 4,
  parameter int PRW    = 2,
  localparam int CHW   = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_trig,
  input  logic [NCH-1:0] par_mask,
  input  logic           q_wr,
  input  logic [CHW-1:0] q_wr_ch,
  input  logic           ins_req,
  input  logic [CHW-1:0] ins_ch,
  input  logic [PRW-1:0] par_prio,
  input  logic [PRW-1:0] q_prio,
  input  logic [PRW-1:0] ins_prio,
  input  logic           conv_done,
  output logic           conv_start,
  output logic [CHW-1:0] conv_ch,
  output logic [1:0]     conv_src,
  output logic           busy,
  output logic           q_full,
  output logic           q_empty,
  output logic           q_ovf
);
  logic           p_any, take_p, take_q, take_i, i_v;
  logic [CHW-1:0] p_low, q_head, i_held;

  adc_par_src #(.NCH(NCH)) par_i (
    .clk(clk), .rst(rst), .trig(par_trig), .mask(par_mask),
    .take(take_p), .any(p_any), .low_ch(p_low)
  );

  adc_req_fifo #(.DEPTH(QDEPTH), .W(CHW)) que_i (
    .clk(clk), .rst(rst), .wr(q_wr), .wdata(q_wr_ch), .rd(take_q),
    .rdata(q_head), .full(q_full), .empty(q_empty), .ovf(q_ovf)
  );

  adc_ins_slot #(.CHW(CHW)) ins_i (
    .clk(clk), .rst(rst), .req(ins_req), .ch(ins_ch), .take(take_i),
    .valid(i_v), .held_ch(i_held)
  );

  adc_arb_core #(.CHW(CHW), .PRW(PRW)) core_i (
    .clk(clk), .rst(rst),
    .p_v(p_any), .p_ch(p_low), .p_prio(par_prio),
    .q_v(!q_empty), .q_ch(q_head), .q_prio(q_prio),
    .i_v(i_v), .i_ch(i_held), .i_prio(ins_prio),
    .conv_done(conv_done),
    .take_p(take_p), .take_q(take_q), .take_i(take_i),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_src(conv_src),
    .busy(busy)
  );
endmodule

// File: rtl/adc_req_arbiter_chk.sv
module adc_req_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic       q_wr,
  input logic       conv_done,
  input logic       conv_start,
  input logic [1:0] conv_src,
  input logic       busy,
  input logic       q_full,
  input logic       q_empty,
  input logic       q_ovf
);
  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !$past(busy));
  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !conv_done) |=> busy);
  // R6
  start_src_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (conv_src != 2'd0));
  // R3
  full_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !(q_full && q_empty));
  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (q_wr && q_full) |=> q_ovf);
  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    q_ovf |=> q_ovf);
endmodule

bind adc_req_arbiter adc_req_arbiter_chk chk_i (
  .clk(clk), .rst(rst), .q_wr(q_wr), .conv_done(conv_done),
  .conv_start(conv_start), .conv_src(conv_src), .busy(busy),
  .q_full(q_full), .q_empty(q_empty), .q_ovf(q_ovf)
);

// File: tb/adc_req_arbiter_tb.sv
module adc_req_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        par_trig = 1'b0;
  logic [15:0] par_mask = '0;
  logic        q_wr = 1'b0;
  logic [3:0]  q_wr_ch = '0;
  logic        ins_req = 1'b0;
  logic [3:0]  ins_ch = '0;
  logic [1:0]  par_prio = '0, q_prio = '0, ins_prio = '0;
  logic        conv_done = 1'b0;
  logic        conv_start, busy, q_full, q_empty, q_ovf;
  logic [3:0]  conv_ch;
  logic [1:0]  conv_src;

  adc_req_arbiter dut_i (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // reference model state
  int m_pend, m_q[4], m_qn, m_iv, m_ich, m_busy, m_ovf;
  int e_start, e_ch, e_src;
  int cdly, lat;
  bit hold;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lowest(int m);
    for (int i = 0; i < 16; i++) if (m[i]) return i;
    return 0;
  endfunction

  // one cycle: drive, advance the model, compare after the edge
  task automatic step(string tag, bit trig, int mask, bit wr, int wch,
                      bit ins, int ich, bit stray);
    int sel, best, ch, oldfull, oldiv;
    bit done;
    done = 0;
    if (m_busy != 0) begin
      if (cdly == 0 && !hold) done = 1;
      else if (cdly > 0) cdly--;
    end else if (stray) done = 1;
    par_trig = trig; par_mask = mask[15:0]; q_wr = wr; q_wr_ch = wch[3:0];
    ins_req = ins; ins_ch = ich[3:0]; conv_done = done;
    sel = 0; best = 0; ch = 0;
    if (m_busy == 0) begin
      if (m_pend != 0) begin sel = 1; best = par_prio; ch = lowest(m_pend); end
      if (m_qn > 0 && (sel == 0 || q_prio >= best)) begin
        sel = 2; best = q_prio; ch = m_q[0];
      end
      if (m_iv != 0 && (sel == 0 || ins_prio >= best)) begin sel = 3; ch = m_ich; end
    end
    e_start = (sel != 0);
    if (sel != 0) begin e_ch = ch; e_src = sel; m_busy = 1; cdly = lat; end
    else if (m_busy != 0 && done) m_busy = 0;
    if (sel == 1) m_pend &= ~(1 << ch);
    if (trig) m_pend |= mask & 16'hFFFF;
    oldfull = (m_qn == 4);
    if (sel == 2) begin
      for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
      m_qn--;
    end
    if (wr && !oldfull) begin m_q[m_qn] = wch; m_qn++; end
    if (wr && oldfull) m_ovf = 1;
    oldiv = m_iv;
    if (sel == 3) m_iv = 0;
    if (ins && oldiv == 0) begin m_iv = 1; m_ich = ich; end
    @(negedge clk);
    chk("R7 conv_start", conv_start, e_start);
    chk("R7 busy", busy, m_busy);
    chk({tag, " conv_ch"}, conv_ch, e_ch);
    chk({tag, " conv_src"}, conv_src, e_src);
    chk("R3 q_full", q_full, m_qn == 4);
    chk("R3 q_empty", q_empty, m_qn == 0);
    chk("R4 q_ovf", q_ovf, m_ovf);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_pend = 0; m_qn = 0; m_iv = 0; m_ich = 0; m_busy = 0; m_ovf = 0;
    e_start = 0; e_ch = 0; e_src = 0; cdly = 0; lat = 1; hold = 0;
    for (int i = 0; i < 4; i++) m_q[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 conv_start", conv_start, 0); chk("R1 busy", busy, 0);
    chk("R1 conv_ch", conv_ch, 0);       chk("R1 conv_src", conv_src, 0);
    chk("R1 q_empty", q_empty, 1);       chk("R1 q_full", q_full, 0);
    chk("R1 q_ovf", q_ovf, 0);

    // R2: fixed order, channel 0 re-pended while the sequence runs
    par_prio = 1; q_prio = 1; ins_prio = 1;
    step("R2", 1, 16'h8A05, 0, 0, 0, 0, 0);
    idle("R2", 2);
    step("R2", 1, 16'h0001, 0, 0, 0, 0, 0);
    idle("R2", 30);

    // R9: insertion and queue entry cut into a running sequence
    step("R9", 1, 16'h0F00, 0, 0, 0, 0, 0);
    idle("R9", 3);
    step("R9", 0, 0, 1, 2, 1, 7, 0);
    idle("R9", 30);

    // R3/R4: fill queue while converter is held, then write during pops
    hold = 1;
    step("R3", 0, 0, 0, 0, 1, 3, 0);
    step("R3", 0, 0, 1, 9, 0, 0, 0);
    step("R3", 0, 0, 1, 4, 0, 0, 0);
    step("R3", 0, 0, 1, 12, 0, 0, 0);
    step("R3", 0, 0, 1, 1, 0, 0, 0);
    step("R4", 0, 0, 1, 6, 0, 0, 0);
    hold = 0;
    for (int i = 0; i < 8; i++) step("R4", 0, 0, 1, 10 + (i % 4), 0, 0, 0);
    idle("R3", 40);

    // R5: second insertion while the slot is held is dropped
    hold = 1;
    step("R5", 1, 16'h0002, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 1, 5, 0);
    step("R5", 0, 0, 0, 0, 1, 6, 0);
    hold = 0;
    idle("R5", 12);

    // R6: priority orders and ties
    hold = 1;
    par_prio = 3; q_prio = 1; ins_prio = 2;
    step("R6", 1, 16'h0030, 1, 8, 1, 14, 0);
    step("R6", 0, 0, 1, 13, 0, 0, 0);
    hold = 0;
    idle("R6", 25);
    hold = 1;
    par_prio = 2; q_prio = 2; ins_prio = 2;
    step("R6", 1, 16'h4000, 1, 11, 1, 15, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0);
    hold = 0;
    idle("R6", 20);

    // R8: done pulses while idle must not disturb the next conversion
    step("R8", 0, 0, 0, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 0, 0, 0, 1);
    step("R8", 1, 16'h0100, 0, 0, 0, 0, 1);
    lat = 2;
    idle("R8", 8);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) begin
        par_prio = 2'($urandom); q_prio = 2'($urandom); ins_prio = 2'($urandom);
      end
      lat = $urandom % 4;
      step("R6", ($urandom % 8) == 0, $urandom & 16'hFFFF, ($urandom % 4) == 0,
           $urandom % 16, ($urandom % 10) == 0, $urandom % 16, ($urandom % 5) == 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule